// File: doc/BRIEF.md
# Multi-mode DMA address generator

This block turns one memory request from a network coprocessor's bus master into a 32-bit bus address and a set of byte-lane enables. Each request names what is being reached: a control structure (command block, frame or buffer descriptor, system control block) or a data buffer. It also carries a shared structure base, a 16-bit offset, a full linear pointer, a word index for stepping through multi-word headers, an access size and the byte order. Three addressing modes are selectable: a legacy mode with 24-bit addresses, a 32-bit segmented mode and a purely linear mode.

In the two segmented modes a control structure is placed at base plus offset plus four times the word index. The sum carries into the bits above the 64 KB segment, so a header that runs past the segment end continues at the next contiguous address. Data buffers always take the linear pointer. In linear mode nothing is placed relative to a base. A 32-bit access requested while big-endian order is selected is refused with an error flag, and no address is produced.

The result is registered one cycle after the request. A small state machine records whether the previous cycle produced an address, a fault or nothing. Its states are `ST_IDLE`, `ST_ISSUE` and `ST_FAULT`. From any state the machine moves to `ST_ISSUE` on a legal request, to `ST_FAULT` on a big-endian dword request, and to `ST_IDLE` when `req_valid_i` is low.

Top module: `dma_addr_gen`

## Requirements
- R1: The outputs are registered. `addr_valid_o` is high in the cycle after a legal request. In any cycle after a clock edge with no request, and throughout reset, `addr_valid_o`, `size_err_o`, `addr_o` and `byte_en_o` are all zero.
- R2: In legacy mode (`mode_i` = 2'b00), a structure address is base + offset + 4*index, truncated to 24 bits, with bits 31..24 zero. A buffer address is `lin_ptr_i[23:0]` with bits 31..24 zero.
- R3: In 32-bit segmented mode (`mode_i` = 2'b01), a structure address is base + offset + 4*index modulo 2^32. The offset sum is not wrapped at 16 bits.
- R4: In linear mode (`mode_i` = 2'b10 or 2'b11), a buffer address is `lin_ptr_i` and a structure address is `lin_ptr_i` + 4*index. Base and offset have no effect.
- R5: A buffer request (`is_buffer_i` = 1) in either segmented mode ignores base, offset and index.
- R6: Size encoding is 00 byte, 01 word, 10 or 11 dword. In little-endian order (`big_endian_i` = 0), with a = `addr_o[1:0]`: a byte enables lane a only; a word enables 4'b0011 when a[1] = 0 and 4'b1100 otherwise; a dword enables 4'b1111.
- R7: In big-endian order, a byte enables lane {a[1], ~a[0]}, so the lane is swapped within its 16-bit half. A word enables the same half as in little-endian order.
- R8: A dword request in big-endian order raises `size_err_o` in the next cycle. In that cycle `addr_valid_o` is low and `addr_o` and `byte_en_o` are zero.
- R9: Requests on consecutive cycles produce results on consecutive cycles, and a fault does not disturb the request that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| mode_i | input | 2 | Addressing mode: 00 legacy 24-bit, 01 segmented 32-bit, 1x linear |
| is_buffer_i | input | 1 | 1 = data buffer, 0 = control structure |
| size_i | input | 2 | Access size: 00 byte, 01 word, 1x dword |
| big_endian_i | input | 1 | Big-endian byte order |
| struct_base_i | input | 32 | Shared structure base |
| offset_i | input | 16 | Structure offset |
| lin_ptr_i | input | 32 | Linear pointer |
| word_idx_i | input | 4 | Dword step within a header |
| addr_o | output | 32 | Bus address |
| byte_en_o | output | 4 | Byte-lane enables |
| addr_valid_o | output | 1 | Address valid |
| size_err_o | output | 1 | Illegal big-endian dword request |

## Verification
The bench goes after these cases:
- A legacy sum that carries out of 24 bits. A design that forgot the truncation would leak a one into bit 24.
- A segmented offset plus step that passes 0xFFFF. A design that wrapped inside the segment would land 64 KB too low.
- Inputs that must be ignored: base and offset in linear mode, and base, offset and index on buffer requests. Each is given a nonzero value, so a design that added any of them returns a shifted address.
- Big-endian byte lanes and the big-endian dword fault, followed at once by a legal request. A design with lanes left in little-endian order, or with a fault that lingers, shows the wrong enables or a stuck error flag.

// File: rtl/dag_pkg.sv
package dag_pkg;

    typedef enum logic [1:0] {
        AM_LEGACY24   = 2'b00,
        AM_SEG32      = 2'b01,
        AM_LINEAR     = 2'b10,
        AM_LINEAR_ALT = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE      = 2'b00,
        SZ_WORD      = 2'b01,
        SZ_DWORD     = 2'b10,
        SZ_DWORD_ALT = 2'b11
    } asize_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ISSUE = 2'b01,
        ST_FAULT = 2'b10
    } fsm_e;

endpackage

// File: rtl/dag_addr_calc.sv
module dag_addr_calc
    import dag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int IDX_W  = 4,
    parameter int LEG_W  = 24
) (
    input  logic [1:0]        mode_i,
    input  logic              is_buffer_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [ADDR_W-1:0] lin_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int EXT_W  = OFF_W + IDX_W + 2;
    localparam int HIGH_W = ADDR_W - LEG_W;

    logic [EXT_W-1:0]  ext_off;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] seg_sum;
    logic [ADDR_W-1:0] leg_sum;
    logic [ADDR_W-1:0] leg_lin;

    // offset is widened before the step is added, so a header never wraps in its segment
    assign ext_off = {{(IDX_W+2){1'b0}}, offset_i} + {{OFF_W{1'b0}}, idx_i, 2'b00};
    assign step    = {{(ADDR_W-IDX_W-2){1'b0}}, idx_i, 2'b00};
    assign seg_sum = base_i + {{(ADDR_W-EXT_W){1'b0}}, ext_off};
    assign leg_sum = {{HIGH_W{1'b0}}, seg_sum[LEG_W-1:0]};
    assign leg_lin = {{HIGH_W{1'b0}}, lin_i[LEG_W-1:0]};

    always_comb begin
        unique case (amode_e'(mode_i))
            AM_LEGACY24: addr_o = is_buffer_i ? leg_lin : leg_sum;
            AM_SEG32:    addr_o = is_buffer_i ? lin_i   : seg_sum;
            default:     addr_o = is_buffer_i ? lin_i   : lin_i + step;
        endcase
    end

endmodule

// File: rtl/dag_lane_dec.sv
module dag_lane_dec
    import dag_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [$clog2(LANES)-1:0] lane_sel_i,
    input  logic [1:0]               size_i,
    input  logic                     big_endian_i,
    output logic [LANES-1:0]         be_o
);

    localparam int SEL_W = $clog2(LANES);

    logic [SEL_W-1:0] byte_lane;

    // big-endian bytes swap position inside their 16-bit half
    assign byte_lane = big_endian_i ? (lane_sel_i ^ SEL_W'(1)) : lane_sel_i;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [SEL_W-1:0] LANE_ID = SEL_W'(l);
        logic byte_hit;
        logic half_hit;
        assign byte_hit = (byte_lane == LANE_ID);
        assign half_hit = ((lane_sel_i >> 1) == (LANE_ID >> 1));
        always_comb begin
            unique case (asize_e'(size_i))
                SZ_BYTE: be_o[l] = byte_hit;
                SZ_WORD: be_o[l] = half_hit;
                default: be_o[l] = 1'b1;
            endcase
        end
    end

    always_comb begin
        if (size_i == SZ_BYTE) begin
            assert_byte_single_lane_R6: assert ($countones(be_o) == 1);
        end
    end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int IDX_W  = 4,
    parameter int LEG_W  = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    input  logic [1:0]           mode_i,
    input  logic                 is_buffer_i,
    input  logic [1:0]           size_i,
    input  logic                 big_endian_i,
    input  logic [ADDR_W-1:0]    struct_base_i,
    input  logic [OFF_W-1:0]     offset_i,
    input  logic [ADDR_W-1:0]    lin_ptr_i,
    input  logic [IDX_W-1:0]     word_idx_i,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [ADDR_W/8-1:0]  byte_en_o,
    output logic                 addr_valid_o,
    output logic                 size_err_o
);

    localparam int LANES = ADDR_W / 8;
    localparam int SEL_W = $clog2(LANES);

    fsm_e              state_q, state_d;
    logic [ADDR_W-1:0] calc_addr, addr_q;
    logic [LANES-1:0]  calc_be, be_q;
    logic              bad_size;

    dag_addr_calc #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEG_W(LEG_W)
    ) u_calc (
        .mode_i      (mode_i),
        .is_buffer_i (is_buffer_i),
        .base_i      (struct_base_i),
        .offset_i    (offset_i),
        .lin_i       (lin_ptr_i),
        .idx_i       (word_idx_i),
        .addr_o      (calc_addr)
    );

    dag_lane_dec #(
        .LANES(LANES)
    ) u_lanes (
        .lane_sel_i   (calc_addr[SEL_W-1:0]),
        .size_i       (size_i),
        .big_endian_i (big_endian_i),
        .be_o         (calc_be)
    );

    assign bad_size = big_endian_i && size_i[1];

    always_comb begin
        state_d = ST_IDLE;
        if (req_valid_i) begin
            state_d = bad_size ? ST_FAULT : ST_ISSUE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            be_q   <= '0;
        end else if (req_valid_i && !bad_size) begin
            addr_q <= calc_addr;
            be_q   <= calc_be;
        end else begin
            addr_q <= '0;
            be_q   <= '0;
        end
    end

    always_comb begin
        addr_valid_o = 1'b0;
        size_err_o   = 1'b0;
        unique case (state_q)
            ST_ISSUE: addr_valid_o = 1'b1;
            ST_FAULT: size_err_o   = 1'b1;
            default:  ;
        endcase
    end

    assign addr_o    = addr_q;
    assign byte_en_o = be_q;

    assert_quiet_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!addr_valid_o && !size_err_o && addr_o == '0));

    assert_legacy_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && mode_i == AM_LEGACY24) |=> (addr_o[ADDR_W-1:LEG_W] == '0));

    assert_linear_buffer_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && mode_i[1] && is_buffer_i && !bad_size) |=> (addr_o == $past(lin_ptr_i)));

    assert_dword_all_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !big_endian_i && size_i[1]) |=> (byte_en_o == '1));

    assert_be_dword_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && bad_size) |=> (size_err_o && !addr_valid_o && byte_en_o == '0));

    assert_legal_issues_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !bad_size) |=> (addr_valid_o && !size_err_o));

endmodule

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;

    typedef struct packed {
        logic [1:0]  mode;
        logic        isbuf;
        logic [1:0]  size;
        logic        bige;
        logic [31:0] base;
        logic [15:0] off;
        logic [31:0] lin;
        logic [3:0]  idx;
        logic [31:0] xaddr;
        logic [3:0]  xbe;
        logic        xerr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        // R2 legacy structure, word LE
        '{2'b00, 1'b0, 2'b01, 1'b0, 32'hAB12_3400, 16'h0010, 32'hDEAD_BEEF, 4'h0, 32'h0012_3410, 4'b0011, 1'b0},
        // R2 legacy sum carries past 24 bits
        '{2'b00, 1'b0, 2'b10, 1'b0, 32'h00FF_FFF0, 16'h0020, 32'hDEAD_BEEF, 4'h1, 32'h0000_0014, 4'b1111, 1'b0},
        // R2 legacy buffer, byte LE, index ignored
        '{2'b00, 1'b1, 2'b00, 1'b0, 32'h1111_1111, 16'h2222, 32'h5566_7783, 4'h3, 32'h0066_7783, 4'b1000, 1'b0},
        // R3 segmented offset runs past 0xFFFF
        '{2'b01, 1'b0, 2'b10, 1'b0, 32'h1000_0000, 16'hFFFC, 32'hDEAD_BEEF, 4'h2, 32'h1001_0004, 4'b1111, 1'b0},
        // R7 big-endian byte lane swap
        '{2'b01, 1'b0, 2'b00, 1'b1, 32'h2000_0100, 16'h0002, 32'hDEAD_BEEF, 4'h0, 32'h2000_0102, 4'b1000, 1'b0},
        // R5 segmented buffer, big-endian word
        '{2'b01, 1'b1, 2'b01, 1'b1, 32'h0000_1234, 16'h0055, 32'hCAFE_0006, 4'h3, 32'hCAFE_0006, 4'b1100, 1'b0},
        // R4 linear structure, base and offset ignored
        '{2'b10, 1'b0, 2'b01, 1'b0, 32'hFFFF_0000, 16'h1111, 32'h8000_0000, 4'h5, 32'h8000_0014, 4'b0011, 1'b0},
        // R4 linear buffer, alternate mode code
        '{2'b11, 1'b1, 2'b00, 1'b0, 32'hFFFF_0000, 16'h1111, 32'h0123_4561, 4'h7, 32'h0123_4561, 4'b0010, 1'b0},
        // R8 big-endian dword refused
        '{2'b01, 1'b0, 2'b11, 1'b1, 32'h3000_0000, 16'h0040, 32'hDEAD_BEEF, 4'h0, 32'h0000_0000, 4'b0000, 1'b1},
        // R6 little-endian byte lane 3, right after a fault
        '{2'b01, 1'b0, 2'b00, 1'b0, 32'h0000_0003, 16'h0000, 32'hDEAD_BEEF, 4'h0, 32'h0000_0003, 4'b1000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  mode = '0;
    logic        isbuf = 1'b0;
    logic [1:0]  size = '0;
    logic        bige = 1'b0;
    logic [31:0] base = '0;
    logic [15:0] off = '0;
    logic [31:0] lin = '0;
    logic [3:0]  idx = '0;
    logic [31:0] addr;
    logic [3:0]  ben;
    logic        aval;
    logic        serr;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .mode_i(mode),
        .is_buffer_i(isbuf), .size_i(size), .big_endian_i(bige),
        .struct_base_i(base), .offset_i(off), .lin_ptr_i(lin), .word_idx_i(idx),
        .addr_o(addr), .byte_en_o(ben), .addr_valid_o(aval), .size_err_o(serr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string vtag(input int k);
        case (k)
            0, 1, 2: return "R2";
            3:       return "R3";
            4:       return "R7";
            5:       return "R5";
            6, 7:    return "R4";
            8:       return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic drive(input vec_t v, input logic valid);
        req_valid = valid;
        mode = v.mode; isbuf = v.isbuf; size = v.size; bige = v.bige;
        base = v.base; off = v.off; lin = v.lin; idx = v.idx;
    endtask

    task automatic check_vec(input int k);
        check({vtag(k), " addr"}, addr, VEC[k].xaddr);
        check({vtag(k), " lanes"}, {28'h0, ben}, {28'h0, VEC[k].xbe});
        check({vtag(k), " R9 valid"}, {31'h0, aval}, {31'h0, ~VEC[k].xerr});
        check({vtag(k), " R9 err"}, {31'h0, serr}, {31'h0, VEC[k].xerr});
    endtask

    task automatic check_idle(input string tag);
        check({tag, " valid"}, {31'h0, aval}, 32'h0);
        check({tag, " err"}, {31'h0, serr}, 32'h0);
        check({tag, " addr"}, addr, 32'h0);
        check({tag, " lanes"}, {28'h0, ben}, 32'h0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            n_bad++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs at zero even with a request present
        drive(VEC[3], 1'b1);
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        drive(VEC[0], 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        // table walk, one request per cycle (R9)
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            if (k > 0) check_vec(k - 1);
            drive(VEC[k], 1'b1);
        end
        @(negedge clk);
        check_vec(NV - 1);
        drive(VEC[0], 1'b0);
        @(negedge clk);
        check_idle("R1 no request");

        // R7: big-endian word stays on the little-endian half
        drive(VEC[0], 1'b1);
        bige = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 word lanes", {28'h0, ben}, 32'h3);
        check("R7 word addr", addr, 32'h0012_3410);

        // R8: a lone big-endian dword, then an idle cycle clears the flag
        @(negedge clk);
        drive(VEC[8], 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 err flag", {31'h0, serr}, 32'h1);
        check("R8 no addr", addr, 32'h0);
        @(negedge clk);
        check_idle("R8 cleared");

        // R3: segmented structure with the largest index and offset
        drive(VEC[3], 1'b1);
        off = 16'hFFFF; idx = 4'hF; base = 32'hFFFF_FFF0;
        @(negedge clk);
        req_valid = 1'b0;
        // 0xFFFFFFF0 + 0xFFFF + 0x3C = 0x1_0001_002B -> 0x0001_002B
        check("R3 max sum", addr, 32'h0001_002B);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule